// File: doc/BRIEF.md
# Bipolar XNOR-Popcount Dot-Product Unit

This block forms the dot product of two vectors whose elements can only be -1 or +1. Each element is stored as one bit, and many elements are packed side by side into one wide word. The block does no multiplications. For each word it XNORs the activation bits with the weight bits, counts the agreeing positions and turns that count into a signed partial sum. When the last word of a vector arrives, the accumulated sum is multiplied by an unsigned fixed-point scale. The scaled value is rounded and clipped to the output width before it is presented.

A vector can span any number of words. The word that carries the start flag clears the running sum before it is added. The word that carries the end flag releases the result three cycles later, and that word also supplies the scale. A word with both flags set is a complete one-word vector. Words can be issued on every cycle, and idle cycles may appear anywhere, including inside a vector.

Top module: `bxd_dot_unit`

## Requirements
- R1: Bit value 1 stands for +1 and bit value 0 stands for -1. A one-word vector with scale 16 (1.0) yields 2*m - WORD_W, where m is the number of bit positions at which `in_act` and `in_wgt` agree.
- R2: `out_valid` is high for one cycle exactly 3 cycles after each accepted word that has `in_last` set. It is never high at any other time.
- R3: An accepted word with `in_first` set discards the running sum. Every accepted word adds its partial sum, and the result covers all words from the first one through the last one.
- R4: `in_scale` is an unsigned 8-bit value with 4 fractional bits. Only the value presented with the `in_last` word is used, and the output is sum*scale/16. A scale of 0 gives 0.
- R5: A scaled value with a fractional part of exactly one half is rounded away from zero: 0.5 becomes 1 and -0.5 becomes -1. A fraction below one half is dropped toward zero.
- R6: A scaled value outside the signed OUT_W range is clipped to 32767 or -32768 (default OUT_W=16).
- R7: During reset and afterwards `out_valid` is 0. After reset the running sum is 0, so a vector that starts without `in_first` begins from zero.
- R8: Cycles with `in_valid` low leave the running sum unchanged, including when they fall inside a vector.
- R9: One word is accepted on every cycle, and one-word vectors issued back to back each produce their own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The input word is present this cycle |
| in_first | input | 1 | This word opens a new vector |
| in_last | input | 1 | This word closes the vector |
| in_act | input | WORD_W | Packed activation bits |
| in_wgt | input | WORD_W | Packed weight bits |
| in_scale | input | SCALE_W | Unsigned scale, FRAC_W fractional bits |
| out_valid | output | 1 | The result is present |
| out_data | output | OUT_W | Signed, scaled, rounded and clipped dot product |

## Verification
The assertions assume that `in_valid` and the flags are 0-or-1 values. They also assume that a vector's running sum stays inside the ACC_W-bit accumulator. The bench's longest vector is 40 words, which keeps the sum near 2560, far below that limit. The exact-value properties read inputs from three cycles earlier, so they only apply to one-word vectors with a full match or a full mismatch at scale 1.0. The stimulus covers these cases directly and also brings in random words, gaps inside vectors and extreme scales.

// File: rtl/bxd_pkg.sv
package bxd_pkg;
   typedef struct packed {
      logic vld;
      logic first;
      logic last;
   } bxd_ctl_t;
endpackage

// File: rtl/bxd_popcnt.sv
module bxd_popcnt #(
   parameter int WORD_W = 64,
   parameter int GROUPS = 4,
   localparam int GRP_W = WORD_W / GROUPS,
   localparam int GPC_W = $clog2(GRP_W + 1),
   localparam int PC_W  = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word,
   output logic [PC_W-1:0]   count
);
   if (WORD_W % GROUPS != 0) begin : g_bad_split
      $error("bxd_popcnt: WORD_W must divide evenly into GROUPS");
   end

   logic [GROUPS-1:0][GPC_W-1:0] grp_q;

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      logic [GPC_W-1:0] grp_sum;
      always_comb begin
         grp_sum = '0;
         for (int i = 0; i < GRP_W; i++)
            grp_sum = grp_sum + GPC_W'(word[g*GRP_W+i]);
      end
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) grp_q[g] <= '0;
         else        grp_q[g] <= grp_sum;
   end

   logic [PC_W-1:0] total;
   always_comb begin
      total = '0;
      for (int g = 0; g < GROUPS; g++)
         total = total + PC_W'(grp_q[g]);
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) count <= '0;
      else        count <= total;
endmodule

// File: rtl/bxd_scaler.sv
module bxd_scaler #(
   parameter int ACC_W    = 20,
   parameter int SCALE_W  = 8,
   parameter int FRAC_W   = 4,
   parameter int OUT_W    = 16,
   parameter bit SCALE_EN = 1'b1,
   localparam int P_W     = ACC_W + SCALE_W + 1
) (
   input  logic signed [ACC_W-1:0]   sum,
   input  logic        [SCALE_W-1:0] scale,
   output logic signed [OUT_W-1:0]   result
);
   if (FRAC_W < 1 || FRAC_W >= SCALE_W) begin : g_bad_frac
      $error("bxd_scaler: FRAC_W must lie in 1..SCALE_W-1");
   end
   if (OUT_W >= P_W || OUT_W > 31) begin : g_bad_out
      $error("bxd_scaler: OUT_W too wide for the product");
   end

   localparam logic [P_W-1:0] POS_LIM = P_W'((64'd1 << (OUT_W-1)) - 1);
   localparam logic [P_W-1:0] NEG_LIM = P_W'(64'd1 << (OUT_W-1));

   logic signed [P_W-1:0] prod;
   logic        [P_W-1:0] mag, rnd, neg_v;
   logic                  neg;

   if (SCALE_EN) begin : g_scaled
      logic signed [SCALE_W:0] scale_s;
      assign scale_s = $signed({1'b0, scale});
      always_comb begin
         prod = P_W'(sum) * P_W'(scale_s);
         neg  = prod[P_W-1];
         mag  = neg ? P_W'(-prod) : P_W'(prod);
         rnd  = (mag + (P_W'(1) << (FRAC_W-1))) >> FRAC_W;
      end
   end else begin : g_bypass
      logic [SCALE_W-1:0] unused_scale;
      assign unused_scale = scale;
      always_comb begin
         prod = P_W'(sum);
         neg  = prod[P_W-1];
         mag  = neg ? P_W'(-prod) : P_W'(prod);
         rnd  = mag;
      end
   end

   always_comb begin
      neg_v = -rnd;
      if (neg)
         result = (rnd > NEG_LIM) ? OUT_W'(NEG_LIM) : neg_v[OUT_W-1:0];
      else
         result = (rnd > POS_LIM) ? OUT_W'(POS_LIM) : rnd[OUT_W-1:0];
   end
endmodule

// File: rtl/bxd_dot_unit.sv
module bxd_dot_unit
   import bxd_pkg::*;
#(
   parameter int WORD_W   = 64,
   parameter int GROUPS   = 4,
   parameter int ACC_W    = 20,
   parameter int SCALE_W  = 8,
   parameter int FRAC_W   = 4,
   parameter int OUT_W    = 16,
   parameter bit SCALE_EN = 1'b1,
   localparam int PC_W    = $clog2(WORD_W + 1),
   localparam int DOT_W   = PC_W + 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic                     in_first,
   input  logic                     in_last,
   input  logic [WORD_W-1:0]        in_act,
   input  logic [WORD_W-1:0]        in_wgt,
   input  logic [SCALE_W-1:0]       in_scale,
   output logic                     out_valid,
   output logic signed [OUT_W-1:0]  out_data
);
   if (ACC_W <= DOT_W) begin : g_bad_acc
      $error("bxd_dot_unit: ACC_W must exceed one word's partial sum");
   end

   // stage 1/2: popcount of agreeing bit positions
   logic [PC_W-1:0] agree_cnt;
   bxd_popcnt #(.WORD_W(WORD_W), .GROUPS(GROUPS)) u_pop (
      .clk   (clk),
      .rst_n (rst_n),
      .word  (~(in_act ^ in_wgt)),
      .count (agree_cnt)
   );

   bxd_ctl_t           ctl_s1, ctl_s2;
   logic [SCALE_W-1:0] scl_s1, scl_s2;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         ctl_s1 <= '0;
         ctl_s2 <= '0;
         scl_s1 <= '0;
         scl_s2 <= '0;
      end else begin
         ctl_s1 <= '{vld: in_valid, first: in_first, last: in_last};
         ctl_s2 <= ctl_s1;
         scl_s1 <= in_scale;
         scl_s2 <= scl_s1;
      end

   // stage 3: signed conversion, accumulation, scaling
   logic signed [DOT_W-1:0] dot;
   logic signed [ACC_W-1:0] acc_q, acc_base, acc_nxt;
   logic signed [OUT_W-1:0] scaled;

   always_comb begin
      dot      = $signed({1'b0, agree_cnt, 1'b0}) - $signed(DOT_W'(WORD_W));
      acc_base = ctl_s2.first ? '0 : acc_q;
      acc_nxt  = acc_base + ACC_W'(dot);
   end

   bxd_scaler #(
      .ACC_W(ACC_W), .SCALE_W(SCALE_W), .FRAC_W(FRAC_W),
      .OUT_W(OUT_W), .SCALE_EN(SCALE_EN)
   ) u_scl (
      .sum    (acc_nxt),
      .scale  (scl_s2),
      .result (scaled)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         acc_q     <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= ctl_s2.vld & ctl_s2.last;
         if (ctl_s2.vld) begin
            acc_q <= acc_nxt;
            if (ctl_s2.last) out_data <= scaled;
         end
      end
endmodule

// File: rtl/bxd_checker.sv
module bxd_checker #(
   parameter int WORD_W   = 64,
   parameter int SCALE_W  = 8,
   parameter int FRAC_W   = 4,
   parameter int OUT_W    = 16,
   parameter bit SCALE_EN = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    in_first,
   input logic                    in_last,
   input logic [WORD_W-1:0]       in_act,
   input logic [WORD_W-1:0]       in_wgt,
   input logic [SCALE_W-1:0]      in_scale,
   input logic                    out_valid,
   input logic signed [OUT_W-1:0] out_data
);
   localparam logic [SCALE_W-1:0] UNITY = SCALE_W'(1 << FRAC_W);
   localparam bit FITS = (WORD_W < (1 << (OUT_W-1)));

   logic one_full_match, one_full_miss;
   assign one_full_match = in_valid && in_first && in_last &&
                           (in_act == in_wgt) && (in_scale == UNITY);
   assign one_full_miss  = in_valid && in_first && in_last &&
                           (in_act == ~in_wgt) && (in_scale == UNITY);

   a_r2_valid_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid && in_last, 3));

   a_r2_last_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last) |-> ##3 out_valid);

   a_r1_full_match: assert property (@(posedge clk) disable iff (!rst_n)
      (FITS && SCALE_EN && out_valid && $past(one_full_match, 3))
         |-> ($signed(out_data) == WORD_W));

   a_r1_full_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
      (FITS && SCALE_EN && out_valid && $past(one_full_miss, 3))
         |-> ($signed(out_data) == -WORD_W));

   a_r4_zero_scale: assert property (@(posedge clk) disable iff (!rst_n)
      (SCALE_EN && out_valid && ($past(in_scale, 3) == '0)) |-> (out_data == '0));

   a_r7_valid_known: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(out_valid));
endmodule

bind bxd_dot_unit bxd_checker #(
   .WORD_W(WORD_W), .SCALE_W(SCALE_W), .FRAC_W(FRAC_W),
   .OUT_W(OUT_W), .SCALE_EN(SCALE_EN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
   .in_last(in_last), .in_act(in_act), .in_wgt(in_wgt), .in_scale(in_scale),
   .out_valid(out_valid), .out_data(out_data)
);

// File: tb/bxd_dot_unit_tb.sv
module bxd_dot_unit_tb;
   localparam int WORD_W = 64;
   localparam int OUT_W  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
   logic [WORD_W-1:0] in_act = '0, in_wgt = '0;
   logic [7:0]        in_scale = '0;
   logic              out_valid;
   logic signed [OUT_W-1:0] out_data;

   int compared = 0, mismatched = 0;
   bit done = 1'b0;
   string cur_tag = "R7";

   always #5 clk = ~clk;

   bxd_dot_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
      .in_last(in_last), .in_act(in_act), .in_wgt(in_wgt), .in_scale(in_scale),
      .out_valid(out_valid), .out_data(out_data)
   );

   // behavioural reference: 3-deep expected-output queue
   bit     qv[3];
   longint qd[3];
   string  qt[3];
   longint racc = 0;

   function automatic longint ref_scale(longint s, int sc);
      longint p, m, r, v;
      p = s * sc;
      m = (p < 0) ? -p : p;
      r = (m + 8) / 16;
      v = (p < 0) ? -r : r;
      if (v > 32767)  v = 32767;
      if (v < -32768) v = -32768;
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 3; k++) begin qv[k] = 0; qd[k] = 0; qt[k] = "R7"; end
         racc = 0;
      end else begin
         qv[2] = qv[1]; qd[2] = qd[1]; qt[2] = qt[1];
         qv[1] = qv[0]; qd[1] = qd[0]; qt[1] = qt[0];
         qv[0] = 0; qt[0] = cur_tag;
         if (in_valid) begin
            int m;
            m = 0;
            for (int j = 0; j < WORD_W; j++)
               if (in_act[j] == in_wgt[j]) m++;
            if (in_first) racc = 0;
            racc += 2*m - WORD_W;
            if (in_last) begin
               qv[0] = 1;
               qd[0] = ref_scale(racc, int'(in_scale));
            end
         end
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         compared++;
         if (out_valid !== qv[2] || (qv[2] && longint'(out_data) != qd[2])) begin
            mismatched++;
            $display("FAIL %s: out_valid=%0b out_data=%0d expected valid=%0b data=%0d",
                     qt[2], out_valid, out_data, qv[2], qd[2]);
         end
      end
   end

   task automatic send(input logic [63:0] a, input logic [63:0] w,
                       input bit f, input bit l, input logic [7:0] s);
      @(negedge clk);
      in_valid = 1; in_first = f; in_last = l; in_act = a; in_wgt = w; in_scale = s;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 0; in_first = 0; in_last = 0;
         in_act = '0; in_wgt = '0; in_scale = '0;
      end
   endtask

   function automatic logic [63:0] rnd64();
      return {$urandom(), $urandom()};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R7: vector without a start flag begins from zero after reset
      cur_tag = "R7";
      send(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 8'd16);
      idle(4);
      // R1: full match, full mismatch, half, random
      cur_tag = "R1";
      send(64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 1, 1, 8'd16);
      send(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1, 1, 8'd16);
      send(64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 8'd16);
      for (int k = 0; k < 20; k++) send(rnd64(), rnd64(), 1, 1, 8'd16);
      idle(4);
      // R3: multi-word vectors, a stray first flag mid-vector restarts
      cur_tag = "R3";
      send(rnd64(), rnd64(), 1, 0, 8'd16);
      send(rnd64(), rnd64(), 0, 0, 8'd16);
      send(rnd64(), rnd64(), 0, 1, 8'd16);
      send(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 8'd16);
      send(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 8'd16);
      idle(4);
      // R8: idle gaps inside a vector
      cur_tag = "R8";
      send(rnd64(), rnd64(), 1, 0, 8'd16);
      idle(3);
      send(rnd64(), rnd64(), 0, 0, 8'd16);
      idle(1);
      send(rnd64(), rnd64(), 0, 1, 8'd16);
      idle(4);
      // R4: scale from last word only, zero scale, random scales
      cur_tag = "R4";
      send(rnd64(), rnd64(), 1, 0, 8'd0);
      send(rnd64(), rnd64(), 0, 1, 8'd40);
      send(rnd64(), rnd64(), 1, 1, 8'd0);
      for (int k = 0; k < 10; k++) send(rnd64(), rnd64(), 1, 1, 8'($urandom()));
      idle(4);
      // R5: dot = +2 / -2 with scale 4 (exact half) and 3 (below half)
      cur_tag = "R5";
      send(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_FFFF_FFFF, 1, 1, 8'd4);
      send(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_7FFF_FFFF, 1, 1, 8'd4);
      send(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_FFFF_FFFF, 1, 1, 8'd3);
      send(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_7FFF_FFFF, 1, 1, 8'd3);
      send(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_FFFF_FFFF, 1, 1, 8'd12);
      idle(4);
      // R6: clipping both ways with 40-word vectors at scale 255
      cur_tag = "R6";
      for (int k = 0; k < 40; k++) send(64'h5A5A, 64'h5A5A, k == 0, k == 39, 8'd255);
      for (int k = 0; k < 40; k++) send(64'h5A5A, ~64'h5A5A, k == 0, k == 39, 8'd255);
      idle(4);
      // R9: back-to-back single-word vectors
      cur_tag = "R9";
      for (int k = 0; k < 16; k++) send(rnd64(), rnd64(), 1, 1, 8'($urandom_range(1, 40)));
      idle(6);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         mismatched++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule